// File: doc/BRIEF.md
# Variable-Page-Size Address Translation Buffer

This block translates 32-bit effective addresses into physical addresses for a 32-bit processor. It is a small, fully associative buffer that software fills entry by entry. Each entry describes one page whose size is chosen per entry from eight options, growing by a factor of four from 1 KB up to 16 MB. Because the size differs per entry, each entry compares a different number of tag bits. Entries of any mix of sizes may be present at the same time. A per-entry zone number selects a two-bit field in a zone-control register, and that field can deny all access, defer to the page's own execute and write bits, or grant full access.

The lookup port takes an effective address, an access kind (fetch, load or store), a translate-enable bit and the current process ID. Exactly one cycle later it returns a physical address together with hit, miss and fault flags. The translate-enable bit travels with each lookup, so the instruction side and the data side can each switch translation on or off on their own. With translation off, the address passes through unchanged and no check is made.

The software port writes, reads back or invalidates one entry at the index that software names. The block never picks a victim entry itself. A separate strobe loads the zone-control register.

Top module: `vtlb_top`

## Requirements
- R1: With `lk_virt` low, a lookup returns `lk_pa` equal to `lk_ea`, with `lk_hit`, `lk_miss` and `lk_fault` all low, whatever the entries and zone settings hold.
- R2: A lookup presented with `lk_req` high at a clock edge produces its result on the outputs after that edge, with `lk_done` high for one cycle. Without a request, `lk_done`, `lk_hit`, `lk_miss` and `lk_fault` are low in the next cycle.
- R3: An entry with size code k (0..7, page size 1 KB × 4^k) matches when `lk_ea[31:10+2k]` equals bits [21:2k] of its 22-bit virtual page number. Entries with different size codes can coexist.
- R4: On a hit with size code k, `lk_pa[9+2k:0]` is taken from `lk_ea` and `lk_pa[31:10+2k]` from bits [21:2k] of the entry's 22-bit physical page number.
- R5: An entry matches only when it is valid and either its 8-bit process ID is zero or it equals `lk_pid`.
- R6: In translate mode with no matching entry, `lk_miss` is high, `lk_hit` and `lk_fault` are low, and `lk_pa` keeps its previous value. `lk_hit` and `lk_miss` are never high together.
- R7: When several valid entries match, the result is taken from the entry with the lowest index.
- R8: Zone z is controlled by bits [2z+1:2z] of the zone-control register. Code 00 faults every access, codes 10 and 11 never fault, and code 01 applies the page permissions. `lk_fault` is only raised together with `lk_hit`.
- R9: Under zone code 01, access kind 00 (fetch) faults when the entry's execute bit is 0. Access kind 10 (store) faults when its write bit is 0. Kinds 01 and 11 (load) never fault.
- R10: Software operation 01 writes all fields of entry `sw_idx`. Operation 10 returns that entry's fields on the `rd_*` outputs in the next cycle, with `rd_done` high. Operation 11 clears only its valid bit. Operation 00 does nothing.
- R11: After reset every entry is invalid, the zone-control register is zero and all lookup outputs are zero.
- R12: A lookup in the same cycle as a software write sees the table as it was before that write. Lookups from the next cycle on see the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_op | input | 2 | Software operation: 00 none, 01 write, 10 read, 11 invalidate |
| sw_idx | input | IDX_W | Entry index for the software operation |
| sw_valid | input | 1 | Valid bit to write |
| sw_vpn | input | 22 | Virtual page number to write (EA bits 31:10) |
| sw_size | input | 3 | Page size code to write |
| sw_pid | input | 8 | Process ID tag to write (0 = any) |
| sw_ppn | input | 22 | Physical page number to write (PA bits 31:10) |
| sw_exec | input | 1 | Execute permission to write |
| sw_write | input | 1 | Write permission to write |
| sw_zone | input | 4 | Zone number to write |
| zone_we | input | 1 | Load the zone-control register |
| zone_wdata | input | 32 | New zone-control value |
| rd_done | output | 1 | Read-back data valid |
| rd_valid | output | 1 | Read-back valid bit |
| rd_vpn | output | 22 | Read-back virtual page number |
| rd_size | output | 3 | Read-back size code |
| rd_pid | output | 8 | Read-back process ID tag |
| rd_ppn | output | 22 | Read-back physical page number |
| rd_exec | output | 1 | Read-back execute permission |
| rd_write | output | 1 | Read-back write permission |
| rd_zone | output | 4 | Read-back zone number |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| lk_virt | input | 1 | 1 = translate, 0 = pass through |
| lk_pid | input | 8 | Current process ID |
| lk_done | output | 1 | Lookup result valid |
| lk_pa | output | 32 | Physical address |
| lk_hit | output | 1 | Translation hit |
| lk_miss | output | 1 | Translation miss |
| lk_fault | output | 1 | Protection fault on a hit |

## Verification
The bench builds the block with `ENTRIES` set to 4. With only four entries, a short run exercises every index often, including collisions where several entries cover one address and the lowest-index rule must decide. The narrow index also lets a random mix of writes, invalidates, zone reloads and lookups reach almost every combination of entry state. Every size code is swept with addresses inside its page, just across its top boundary and just below it. The full cross of zone code, access kind and permission bits is applied, and the expected results come from shift arithmetic on a table the bench keeps itself.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 10;
    localparam int TAG_W    = VA_W - PG_SHIFT;
    localparam int SZ_W     = 3;
    localparam int PID_W    = 8;
    localparam int ZONES    = 16;
    localparam int ZN_W     = $clog2(ZONES);
    localparam int ZCTL_W   = 2 * ZONES;

    typedef enum logic [1:0] {
        SW_NOP   = 2'd0,
        SW_WRITE = 2'd1,
        SW_READ  = 2'd2,
        SW_INVAL = 2'd3
    } sw_op_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ZN_DENY  = 2'd0,
        ZN_PAGE  = 2'd1,
        ZN_FULL  = 2'd2,
        ZN_FULL2 = 2'd3
    } zone_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  vpn;
        logic [SZ_W-1:0]   size;
        logic [PID_W-1:0]  pid;
        logic [TAG_W-1:0]  ppn;
        logic              ex;
        logic              wr;
        logic [ZN_W-1:0]   zone;
    } pte_t;

    // Tag bits that take part in the compare for a given size code.
    function automatic logic [TAG_W-1:0] tag_keep(input logic [SZ_W-1:0] sz);
        logic [TAG_W-1:0] m;
        m = '1;
        m = m << (2 * int'(sz));
        return m;
    endfunction

    // Address bits that pass straight through for a given size code.
    function automatic logic [VA_W-1:0] offset_mask(input logic [SZ_W-1:0] sz);
        logic [VA_W-1:0] m;
        m = '1;
        m = m << (PG_SHIFT + 2 * int'(sz));
        return ~m;
    endfunction

endpackage

// File: rtl/vtlb_entry_store.sv
module vtlb_entry_store
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               sw_op,
    input  logic [IDX_W-1:0]         sw_idx,
    input  pte_t                     sw_entry,
    input  logic                     zone_we,
    input  logic [ZCTL_W-1:0]        zone_wdata,
    output pte_t [ENTRIES-1:0]       tbl,
    output logic [ZCTL_W-1:0]        zctl,
    output pte_t                     rd_entry,
    output logic                     rd_done
);

    typedef struct packed {
        pte_t [ENTRIES-1:0] tbl;
        logic [ZCTL_W-1:0]  zctl;
        pte_t               rd;
        logic               rd_v;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rd_v = 1'b0;
        case (sw_op_e'(sw_op))
            SW_WRITE: st_d.tbl[sw_idx] = sw_entry;
            SW_READ: begin
                st_d.rd   = st_q.tbl[sw_idx];
                st_d.rd_v = 1'b1;
            end
            SW_INVAL: st_d.tbl[sw_idx].valid = 1'b0;
            default: ;
        endcase
        if (zone_we) begin
            st_d.zctl = zone_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl      = st_q.tbl;
    assign zctl     = st_q.zctl;
    assign rd_entry = st_q.rd;
    assign rd_done  = st_q.rd_v;

endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  pte_t [ENTRIES-1:0]  tbl,
    input  logic [VA_W-1:0]     ea,
    input  logic [PID_W-1:0]    pid,
    output logic                hit,
    output logic [VA_W-1:0]     pa,
    output logic                sel_ex,
    output logic                sel_wr,
    output logic [ZN_W-1:0]     sel_zone
);

    logic [TAG_W-1:0]   ea_tag;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   sel_idx;
    logic [VA_W-1:0]    pass_mask;
    logic [VA_W-1:0]    frame;

    assign ea_tag = ea[VA_W-1:PG_SHIFT];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [TAG_W-1:0] keep;
        logic             pid_ok;
        logic             tag_ok;
        assign keep       = tag_keep(tbl[i].size);
        assign pid_ok     = (tbl[i].pid == '0) || (tbl[i].pid == pid);
        assign tag_ok     = ((ea_tag ^ tbl[i].vpn) & keep) == '0;
        assign hit_vec[i] = tbl[i].valid && pid_ok && tag_ok;
    end

    // Lowest matching index wins: scan downward, last write sticks.
    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx = IDX_W'(i);
            end
        end
    end

    assign hit       = |hit_vec;
    assign pass_mask = offset_mask(tbl[sel_idx].size);
    assign frame     = {tbl[sel_idx].ppn, {PG_SHIFT{1'b0}}};
    assign pa        = (frame & ~pass_mask) | (ea & pass_mask);
    assign sel_ex    = tbl[sel_idx].ex;
    assign sel_wr    = tbl[sel_idx].wr;
    assign sel_zone  = tbl[sel_idx].zone;

endmodule

// File: rtl/vtlb_perm.sv
module vtlb_perm
    import vtlb_pkg::*;
(
    input  logic [1:0]         acc,
    input  logic               ex,
    input  logic               wr,
    input  logic [ZN_W-1:0]    zone,
    input  logic [ZCTL_W-1:0]  zctl,
    output logic               fault
);

    zone_e zc;
    logic  page_fault;

    assign zc = zone_e'(zctl[{zone, 1'b0} +: 2]);

    always_comb begin
        case (acc_e'(acc))
            ACC_FETCH: page_fault = !ex;
            ACC_STORE: page_fault = !wr;
            default:   page_fault = 1'b0;
        endcase
    end

    always_comb begin
        case (zc)
            ZN_DENY: fault = 1'b1;
            ZN_PAGE: fault = page_fault;
            default: fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sw_op,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic               sw_valid,
    input  logic [21:0]        sw_vpn,
    input  logic [2:0]         sw_size,
    input  logic [7:0]         sw_pid,
    input  logic [21:0]        sw_ppn,
    input  logic               sw_exec,
    input  logic               sw_write,
    input  logic [3:0]         sw_zone,
    input  logic               zone_we,
    input  logic [31:0]        zone_wdata,
    output logic               rd_done,
    output logic               rd_valid,
    output logic [21:0]        rd_vpn,
    output logic [2:0]         rd_size,
    output logic [7:0]         rd_pid,
    output logic [21:0]        rd_ppn,
    output logic               rd_exec,
    output logic               rd_write,
    output logic [3:0]         rd_zone,
    input  logic               lk_req,
    input  logic [31:0]        lk_ea,
    input  logic [1:0]         lk_acc,
    input  logic               lk_virt,
    input  logic [7:0]         lk_pid,
    output logic               lk_done,
    output logic [31:0]        lk_pa,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic               lk_fault
);

    pte_t               wr_entry;
    pte_t               rd_entry;
    pte_t [ENTRIES-1:0] tbl;
    logic [ZCTL_W-1:0]  zctl;

    logic               m_hit;
    logic [VA_W-1:0]    m_pa;
    logic               m_ex;
    logic               m_wr;
    logic [ZN_W-1:0]    m_zone;
    logic               p_fault;

    always_comb begin
        wr_entry.valid = sw_valid;
        wr_entry.vpn   = sw_vpn;
        wr_entry.size  = sw_size;
        wr_entry.pid   = sw_pid;
        wr_entry.ppn   = sw_ppn;
        wr_entry.ex    = sw_exec;
        wr_entry.wr    = sw_write;
        wr_entry.zone  = sw_zone;
    end

    vtlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_op      (sw_op),
        .sw_idx     (sw_idx),
        .sw_entry   (wr_entry),
        .zone_we    (zone_we),
        .zone_wdata (zone_wdata),
        .tbl        (tbl),
        .zctl       (zctl),
        .rd_entry   (rd_entry),
        .rd_done    (rd_done)
    );

    vtlb_match #(.ENTRIES(ENTRIES)) u_match (
        .tbl      (tbl),
        .ea       (lk_ea),
        .pid      (lk_pid),
        .hit      (m_hit),
        .pa       (m_pa),
        .sel_ex   (m_ex),
        .sel_wr   (m_wr),
        .sel_zone (m_zone)
    );

    vtlb_perm u_perm (
        .acc   (lk_acc),
        .ex    (m_ex),
        .wr    (m_wr),
        .zone  (m_zone),
        .zctl  (zctl),
        .fault (p_fault)
    );

    typedef struct packed {
        logic            done;
        logic            hit;
        logic            miss;
        logic            fault;
        logic [VA_W-1:0] pa;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.done  = lk_req;
        res_d.hit   = 1'b0;
        res_d.miss  = 1'b0;
        res_d.fault = 1'b0;
        if (lk_req) begin
            if (!lk_virt) begin
                res_d.pa = lk_ea;
            end else if (m_hit) begin
                res_d.pa    = m_pa;
                res_d.hit   = 1'b1;
                res_d.fault = p_fault;
            end else begin
                res_d.miss  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign lk_done  = res_q.done;
    assign lk_pa    = res_q.pa;
    assign lk_hit   = res_q.hit;
    assign lk_miss  = res_q.miss;
    assign lk_fault = res_q.fault;

    assign rd_valid = rd_entry.valid;
    assign rd_vpn   = rd_entry.vpn;
    assign rd_size  = rd_entry.size;
    assign rd_pid   = rd_entry.pid;
    assign rd_ppn   = rd_entry.ppn;
    assign rd_exec  = rd_entry.ex;
    assign rd_write = rd_entry.wr;
    assign rd_zone  = rd_entry.zone;

endmodule

// File: rtl/vtlb_checker.sv
module vtlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  sw_op,
    input logic        rd_done,
    input logic        lk_req,
    input logic        lk_virt,
    input logic [31:0] lk_ea,
    input logic        lk_done,
    input logic [31:0] lk_pa,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic        lk_fault
);

    // R1
    real_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_virt |=> lk_pa == $past(lk_ea) && !lk_hit && !lk_miss && !lk_fault);

    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_done && !lk_hit && !lk_miss && !lk_fault);

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_virt |=> !lk_hit || lk_pa[9:0] == $past(lk_ea[9:0]));

    // R6
    miss_holds_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> $stable(lk_pa));

    // R6
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R8
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R10
    read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_op == 2'd2 |=> rd_done);

endmodule

bind vtlb_top vtlb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_op    (sw_op),
    .rd_done  (rd_done),
    .lk_req   (lk_req),
    .lk_virt  (lk_virt),
    .lk_ea    (lk_ea),
    .lk_done  (lk_done),
    .lk_pa    (lk_pa),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault)
);

// File: tb/vtlb_top_test.sv
module vtlb_top_test;

    localparam int ENT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sw_op = '0;
    logic [1:0]  sw_idx = '0;
    logic        sw_valid = 1'b0;
    logic [21:0] sw_vpn = '0;
    logic [2:0]  sw_size = '0;
    logic [7:0]  sw_pid = '0;
    logic [21:0] sw_ppn = '0;
    logic        sw_exec = 1'b0;
    logic        sw_write = 1'b0;
    logic [3:0]  sw_zone = '0;
    logic        zone_we = 1'b0;
    logic [31:0] zone_wdata = '0;
    logic        rd_done, rd_valid, rd_exec, rd_write;
    logic [21:0] rd_vpn, rd_ppn;
    logic [2:0]  rd_size;
    logic [7:0]  rd_pid;
    logic [3:0]  rd_zone;
    logic        lk_req = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_virt = 1'b0;
    logic [7:0]  lk_pid = '0;
    logic        lk_done, lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_pa;

    vtlb_top #(.ENTRIES(ENT)) uut (.*);

    always #5 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    logic        s_v   [ENT];
    logic [21:0] s_vpn [ENT];
    logic [2:0]  s_sz  [ENT];
    logic [7:0]  s_pid [ENT];
    logic [21:0] s_ppn [ENT];
    logic        s_ex  [ENT];
    logic        s_wr  [ENT];
    logic [3:0]  s_zn  [ENT];
    logic [31:0] s_zctl = '0;
    logic [31:0] last_pa = '0;
    logic [31:0] seed = 32'h1234_5678;
    logic [21:0] pool [4];

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed ^ (seed >> 13);
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Bench-side reference: shift arithmetic on the shadow table.
    task automatic model(input logic [31:0] ea, input logic [1:0] acc, input logic [7:0] pid,
                         output logic h, output logic [31:0] pa, output logic f);
        int sh;
        logic [1:0] zc;
        logic [31:0] base;
        h = 0; pa = '0; f = 0;
        for (int i = ENT - 1; i >= 0; i--) begin
            sh = 10 + 2 * int'(s_sz[i]);
            base = {s_vpn[i], 10'b0};
            if (s_v[i] && (s_pid[i] == 8'd0 || s_pid[i] == pid) && ((ea >> sh) == (base >> sh))) begin
                h  = 1;
                pa = (({s_ppn[i], 10'b0} >> sh) << sh) | (ea & ((32'd1 << sh) - 32'd1));
                zc = 2'((s_zctl >> (2 * int'(s_zn[i]))) & 32'd3);
                f  = (zc == 2'd0) ||
                     (zc == 2'd1 && ((acc == 2'd0 && !s_ex[i]) || (acc == 2'd2 && !s_wr[i])));
            end
        end
    endtask

    task automatic compare_lookup(input logic virt, input logic h, input logic [31:0] pa,
                                  input logic f, input string rq);
        logic eh, em, ef;
        logic [31:0] ep;
        eh = virt && h;
        em = virt && !h;
        ef = virt && h && f;
        ep = em ? last_pa : pa;
        vectors++;
        if (lk_done !== 1'b1 || lk_hit !== eh || lk_miss !== em || lk_fault !== ef || lk_pa !== ep) begin
            errors++;
            $display("FAIL %s: got done=%b hit=%b miss=%b fault=%b pa=%h, exp done=1 hit=%b miss=%b fault=%b pa=%h",
                     rq, lk_done, lk_hit, lk_miss, lk_fault, lk_pa, eh, em, ef, ep);
        end
        last_pa = ep;
    endtask

    task automatic lookup(input logic [31:0] ea, input logic [1:0] acc, input logic virt,
                          input logic [7:0] pid, input string rq);
        logic h, f;
        logic [31:0] pa;
        if (virt) model(ea, acc, pid, h, pa, f);
        else begin h = 0; f = 0; pa = ea; end
        @(negedge clk);
        lk_req = 1; lk_ea = ea; lk_acc = acc; lk_virt = virt; lk_pid = pid;
        @(negedge clk);
        lk_req = 0;
        compare_lookup(virt, h, pa, f, rq);
    endtask

    task automatic drive_write(input int idx, input logic v, input logic [21:0] vpn, input logic [2:0] sz,
                               input logic [7:0] pid, input logic [21:0] ppn, input logic ex,
                               input logic wr, input logic [3:0] zn);
        sw_op = 2'd1; sw_idx = 2'(idx); sw_valid = v; sw_vpn = vpn; sw_size = sz;
        sw_pid = pid; sw_ppn = ppn; sw_exec = ex; sw_write = wr; sw_zone = zn;
        s_v[idx] = v; s_vpn[idx] = vpn; s_sz[idx] = sz; s_pid[idx] = pid;
        s_ppn[idx] = ppn; s_ex[idx] = ex; s_wr[idx] = wr; s_zn[idx] = zn;
    endtask

    task automatic sw_wr(input int idx, input logic v, input logic [21:0] vpn, input logic [2:0] sz,
                         input logic [7:0] pid, input logic [21:0] ppn, input logic ex,
                         input logic wr, input logic [3:0] zn);
        @(negedge clk);
        drive_write(idx, v, vpn, sz, pid, ppn, ex, wr, zn);
        @(negedge clk);
        sw_op = 2'd0;
    endtask

    task automatic sw_inval(input int idx);
        @(negedge clk);
        sw_op = 2'd3; sw_idx = 2'(idx);
        @(negedge clk);
        sw_op = 2'd0;
        s_v[idx] = 0;
    endtask

    task automatic zone_set(input logic [31:0] val);
        @(negedge clk);
        zone_we = 1; zone_wdata = val;
        @(negedge clk);
        zone_we = 0;
        s_zctl = val;
    endtask

    task automatic read_chk(input int idx, input string rq);
        @(negedge clk);
        sw_op = 2'd2; sw_idx = 2'(idx);
        @(negedge clk);
        sw_op = 2'd0;
        vectors++;
        if (rd_done !== 1'b1 || rd_valid !== s_v[idx] || rd_vpn !== s_vpn[idx] || rd_size !== s_sz[idx] ||
            rd_pid !== s_pid[idx] || rd_ppn !== s_ppn[idx] || rd_exec !== s_ex[idx] ||
            rd_write !== s_wr[idx] || rd_zone !== s_zn[idx]) begin
            errors++;
            $display("FAIL %s: entry %0d got {%b %b %h %0d %h %h %b %b %h}, exp {1 %b %h %0d %h %h %b %b %h}",
                     rq, idx, rd_done, rd_valid, rd_vpn, rd_size, rd_pid, rd_ppn, rd_exec, rd_write, rd_zone,
                     s_v[idx], s_vpn[idx], s_sz[idx], s_pid[idx], s_ppn[idx], s_ex[idx], s_wr[idx], s_zn[idx]);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < ENT; i++) sw_inval(i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2: watchdog expired, got no end of run, exp end within limit");
            report();
        end
    end

    initial begin
        for (int i = 0; i < ENT; i++) begin
            s_v[i] = 0; s_vpn[i] = '0; s_sz[i] = '0; s_pid[i] = '0;
            s_ppn[i] = '0; s_ex[i] = 0; s_wr[i] = 0; s_zn[i] = '0;
        end
        for (int i = 0; i < 4; i++) pool[i] = 22'(rnd());
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R11: reset state at the ports
        vectors++;
        if (lk_done !== 0 || lk_hit !== 0 || lk_miss !== 0 || lk_fault !== 0 || lk_pa !== 0 || rd_done !== 0) begin
            errors++;
            $display("FAIL R11: outputs after reset got done=%b hit=%b miss=%b fault=%b pa=%h rd_done=%b, exp all 0",
                     lk_done, lk_hit, lk_miss, lk_fault, lk_pa, rd_done);
        end
        for (int i = 0; i < ENT; i++) read_chk(i, "R11 entry cleared by reset");
        lookup(32'h0000_0000, 2'd1, 1, 8'd0, "R11 empty table misses");
        lookup(32'h8000_1234, 2'd0, 1, 8'd7, "R11 empty table misses");

        // R2: idle cycle after a lookup
        @(negedge clk);
        vectors++;
        if (lk_done !== 0 || lk_hit !== 0 || lk_miss !== 0 || lk_fault !== 0) begin
            errors++;
            $display("FAIL R2: idle cycle got done=%b hit=%b miss=%b fault=%b, exp 0 0 0 0",
                     lk_done, lk_hit, lk_miss, lk_fault);
        end

        // R1: pass-through with a populated, denying table
        sw_wr(0, 1, 22'h0, 3'd7, 8'd0, 22'h3F_FFFF, 0, 0, 4'd0);
        for (int n = 0; n < 64; n++) lookup(rnd(), 2'(n), 0, 8'(n), "R1 real mode");

        // R3/R4: every size code, inside, at and just below the page edge
        zone_set(32'hAAAA_AAAA);
        clear_all();
        for (int k = 0; k < 8; k++) begin
            for (int t = 0; t < 16; t++) begin
                logic [21:0] vpn;
                logic [31:0] base, off;
                int sh;
                vpn  = 22'(rnd());
                sh   = 10 + 2 * k;
                base = {vpn, 10'b0};
                off  = rnd() & ((32'd1 << sh) - 32'd1);
                sw_wr(1, 1, vpn, 3'(k), 8'd0, 22'(rnd()), 1, 1, 4'(t));
                lookup((base & ~((32'd1 << sh) - 32'd1)) | off, 2'(t), 1, 8'(rnd()), "R3 R4 inside page");
                lookup(((base & ~((32'd1 << sh) - 32'd1)) | off) ^ (32'd1 << sh), 2'd1, 1, 8'd3,
                       "R3 R6 next page misses");
                lookup(((base & ~((32'd1 << sh) - 32'd1)) | off) ^ (32'd1 << (sh - 1)), 2'd2, 1, 8'd3,
                       "R3 R4 top offset bit");
            end
        end
        read_chk(1, "R10 read after write");

        // R3: mixed sizes side by side
        clear_all();
        sw_wr(0, 1, 22'h00_0400, 3'd0, 8'd0, 22'h11_1111, 1, 1, 4'd1);
        sw_wr(2, 1, 22'h04_0000, 3'd7, 8'd0, 22'h2A_BCDE, 1, 1, 4'd1);
        lookup(32'h0010_03FF, 2'd1, 1, 8'd0, "R3 1KB entry among mixed");
        lookup(32'h1012_3456, 2'd1, 1, 8'd0, "R3 16MB entry among mixed");
        lookup(32'h1112_3456, 2'd1, 1, 8'd0, "R3 mixed miss");

        // R5: process ID tag
        sw_wr(1, 1, 22'h12_3450, 3'd1, 8'd5, 22'h0F_0F0C, 1, 1, 4'd2);
        lookup({22'h12_3450, 10'h155}, 2'd1, 1, 8'd5, "R5 pid equal hits");
        lookup({22'h12_3450, 10'h155}, 2'd1, 1, 8'd6, "R5 pid different misses");
        lookup(32'h0010_0000, 2'd1, 1, 8'd99, "R5 pid zero matches any");

        // R7: overlapping entries, lowest index wins
        sw_wr(3, 1, 22'h12_3450, 3'd2, 8'd0, 22'h33_3330, 1, 1, 4'd2);
        sw_wr(0, 1, 22'h12_3451, 3'd0, 8'd0, 22'h00_0A00, 1, 1, 4'd2);
        lookup({22'h12_3451, 10'h0AB}, 2'd1, 1, 8'd5, "R7 entry 0 wins");
        lookup({22'h12_3452, 10'h0AB}, 2'd1, 1, 8'd5, "R7 entry 1 wins over 3");
        sw_inval(0);
        read_chk(0, "R10 invalidate keeps fields");
        lookup({22'h12_3451, 10'h0AB}, 2'd1, 1, 8'd5, "R7 entry 1 after invalidate");
        sw_inval(1);
        lookup({22'h12_3451, 10'h0AB}, 2'd1, 1, 8'd5, "R7 entry 3 after invalidate");

        // R8/R9: zone code x access kind x permission bits
        clear_all();
        for (int zc = 0; zc < 4; zc++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 4; a++) begin
                    logic [3:0] z;
                    z = 4'(rnd());
                    zone_set((rnd() & ~(32'd3 << (2 * int'(z)))) | (32'(zc) << (2 * int'(z))));
                    sw_wr(2, 1, 22'h2F_0000, 3'd3, 8'd0, 22'h01_2340, p[0], p[1], z);
                    lookup(32'hBC00_4321, 2'(a), 1, 8'd1, "R8 R9 zone and page permission");
                end
            end
        end

        // R12: write and lookup in the same cycle
        clear_all();
        @(negedge clk);
        drive_write(0, 1, 22'h15_5500, 3'd0, 8'd0, 22'h2A_AA00, 1, 1, 4'd0);
        lk_req = 1; lk_ea = 32'h5554_0123; lk_acc = 2'd1; lk_virt = 1; lk_pid = 8'd0;
        @(negedge clk);
        sw_op = 2'd0; lk_req = 0;
        compare_lookup(1, 0, 32'h0, 0, "R12 same-cycle lookup sees old table");
        lookup(32'h5554_0123, 2'd1, 1, 8'd0, "R12 next lookup sees new entry");

        // R10: NOP leaves the table alone
        @(negedge clk);
        sw_op = 2'd0; sw_idx = 2'd0; sw_valid = 0; sw_vpn = '1;
        @(negedge clk);
        read_chk(0, "R10 nop has no effect");

        // Mixed random traffic over a small page pool
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            int j;
            r = rnd();
            j = int'(r[9:8]);
            case (r[2:0])
                3'd0, 3'd1: sw_wr(int'(r[5:4]), r[6] | r[7], pool[j], 3'(r[12:10]),
                                  r[13] ? 8'd0 : (r[14] ? 8'd3 : 8'd5), 22'(rnd()), r[15], r[16], 4'(r[20:17]));
                3'd2: sw_inval(int'(r[5:4]));
                3'd3: zone_set(rnd());
                3'd4: read_chk(int'(r[5:4]), "R10 random read-back");
                default: begin
                    logic [31:0] off;
                    off = rnd() >> (8 + int'(r[16:12]) % 24);
                    lookup({pool[j], 10'b0} ^ off, 2'(r[21:20]), r[22] | r[23] | r[24],
                           r[25] ? 8'd3 : 8'd5, "R3 R5 R7 R8 R9 random lookup");
                end
            endcase
        end

        finished = 1;
        report();
    end

endmodule